// File: doc/BRIEF.md
# Serial Flash Command Shifter

This block runs one generic serial-flash transaction at a time on a single-data-line SPI bus. Software writes a bit count and up to six transmit bytes through a small byte-wide register port, then sets a start bit. The opcode lives in the highest transmit slot and is sent first. Any address or data bytes follow from the lower slots, in descending order.

For as many bits as were programmed, the engine lowers chip select and toggles SCLK in mode 0. It shifts the transmit bytes out MSB first and shifts the input line into a seven-byte receive array. The input is also sampled while the opcode goes out, so the byte at the highest filled index is junk. The useful bytes sit below it, with the earliest one at the higher index.

While a transaction runs, the block shows busy, and it ignores every register write. When chip select is released, a one-cycle done pulse marks the end.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 1, busy_o and done_o are 0, and the count, transmit and receive registers read 0.
- R2: Register map, byte wide. Address 0: a write with bit 0 set is a start, and a read returns busy in bit 0. Address 1: bit count. Addresses 2..7: transmit slot 0..5. Addresses 8..14: receive byte 0..6, read only. Address 15 reads 0.
- R3: A bit count written above 56 is stored and read back as 56.
- R4: A start with a stored count of 0 does nothing: busy, chip select and SCLK stay idle.
- R5: Let H be HALF_DIV system clocks. One cycle after the start write, spi_cs_n goes low. For bit k, counted from 0, SCLK is low for H cycles and then high for H cycles. spi_mosi changes only while SCLK is low, and it rests at 1 while chip select is high.
- R6: Bit k on spi_mosi is bit 7-(k mod 8) of transmit slot 5-(k div 8). From bit 48 onwards, spi_mosi is 1.
- R7: The start clears the receive array. spi_miso is sampled on every SCLK rising edge and shifted into bit 0 of a 56-bit array, with earlier bits moving up. Receive byte j holds array bits 8j+7..8j, so after an 8(N+1)-bit transaction the opcode-time byte is at index N and the useful bytes are at N-1 down to 0.
- R8: busy_o rises one cycle after the start write. At 2·n·H cycles after that, with n the count, chip select goes high, busy_o falls and done_o pulses for exactly one cycle.
- R9: While busy_o is 1, including the clock edge on which the transaction ends, writes to any register (start included) have no effect.
- R10: A start written in the cycle done_o is high is accepted, and busy_o is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 4 | register address (read and write) |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data for reg_addr, combinational |
| busy_o | output | 1 | transaction in progress |
| done_o | output | 1 | one-cycle completion pulse |
| spi_cs_n | output | 1 | chip select, active low |
| spi_sclk | output | 1 | serial clock, idles low |
| spi_mosi | output | 1 | serial data to flash |
| spi_miso | input | 1 | serial data from flash |

## Verification
Two things can fall on the same clock edge: the end of a transaction, where busy falls and chip select rises, and a register write arriving from software. The bench issues a write to a transmit slot so that it lands exactly on the edge where the last half period ends, then reads the slot back to confirm the write was dropped. It then issues a start in the cycle that done_o is high and confirms the new transaction begins on the next edge. A behavioural model, built from a cycle counter and bit lists, predicts chip select, SCLK, data out, busy and done on every clock and compares them with the design.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
    localparam int TX_BYTES = 6;
    localparam int RX_BYTES = 7;
    localparam int TX_BITS  = TX_BYTES * 8;
    localparam int MAX_BITS = RX_BYTES * 8;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int HALF_W   = CNT_W + 1;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CNT  = 4'd1;
    localparam logic [3:0] A_TX0  = 4'd2;
    localparam logic [3:0] A_RX0  = 4'd8;

    typedef struct packed {
        logic                busy;
        logic                cs_n;
        logic                sclk;
        logic                done;
        logic [HALF_W-1:0]   half;
        logic [CNT_W-1:0]    nbits;
        logic [TX_BITS-1:0]  tx;
        logic [MAX_BITS-1:0] rx;
    } shift_st_t;

    typedef struct packed {
        logic [CNT_W-1:0]                cnt;
        logic [TX_BYTES-1:0][7:0]        tx;
    } regs_st_t;
endpackage

// File: rtl/sflash_regs.sv
module sflash_regs
    import sflash_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [3:0]          addr,
    input  logic [7:0]          wdata,
    input  logic                busy,
    input  logic [MAX_BITS-1:0] rx,
    output logic [7:0]          rdata,
    output logic                start,
    output logic [CNT_W-1:0]    nbits,
    output logic [TX_BITS-1:0]  tx_flat
);
    regs_st_t q, d;

    always_comb begin
        d = q;
        if (we && !busy) begin
            if (addr == A_CNT) begin
                if (wdata > 8'(MAX_BITS)) d.cnt = CNT_W'(MAX_BITS);
                else                      d.cnt = wdata[CNT_W-1:0];
            end
            for (int i = 0; i < TX_BYTES; i++) begin
                if (addr == A_TX0 + 4'(i)) d.tx[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start   = we && !busy && (addr == A_CTRL) && wdata[0] && (q.cnt != '0);
    assign nbits   = q.cnt;
    assign tx_flat = q.tx;

    always_comb begin
        rdata = 8'h00;
        if (addr == A_CTRL) rdata = {7'b0, busy};
        if (addr == A_CNT)  rdata = 8'(q.cnt);
        for (int i = 0; i < TX_BYTES; i++) begin
            if (addr == A_TX0 + 4'(i)) rdata = q.tx[i];
        end
        for (int j = 0; j < RX_BYTES; j++) begin
            if (addr == A_RX0 + 4'(j)) rdata = rx[8*j +: 8];
        end
    end
endmodule

// File: rtl/sflash_clkgen.sv
module sflash_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int TW = $clog2(HALF_DIV) + 1;

    logic [TW-1:0] tick_q, tick_d;

    assign half_end = run && (tick_q == TW'(HALF_DIV - 1));

    always_comb begin
        tick_d = tick_q;
        if (!run)          tick_d = '0;
        else if (half_end) tick_d = '0;
        else               tick_d = tick_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter
    import sflash_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    nbits,
    input  logic [TX_BITS-1:0]  tx_load,
    input  logic                half_end,
    input  logic                miso,
    output logic                busy,
    output logic                done,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx
);
    shift_st_t q, d;
    logic [HALF_W-1:0] half_nx;

    assign half_nx = q.half + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.cs_n  = 1'b0;
                d.sclk  = 1'b0;
                d.half  = '0;
                d.nbits = nbits;
                d.tx    = tx_load;
                d.rx    = '0;
            end
        end else if (half_end) begin
            d.half = half_nx;
            if (!q.half[0]) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[MAX_BITS-2:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (half_nx == {q.nbits, 1'b0}) begin
                    d.busy = 1'b0;
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                end else begin
                    d.tx = {q.tx[TX_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign done = q.done;
    assign cs_n = q.cs_n;
    assign sclk = q.sclk;
    assign mosi = q.busy ? q.tx[TX_BITS-1] : 1'b1;
    assign rx   = q.rx;
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sflash_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       busy_o,
    output logic       done_o,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic                start;
    logic [CNT_W-1:0]    nbits;
    logic [TX_BITS-1:0]  tx_flat;
    logic [MAX_BITS-1:0] rx;
    logic                half_end;

    sflash_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy_o), .rx(rx), .rdata(reg_rdata), .start(start), .nbits(nbits),
        .tx_flat(tx_flat)
    );

    sflash_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy_o), .half_end(half_end)
    );

    sflash_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits), .tx_load(tx_flat),
        .half_end(half_end), .miso(spi_miso), .busy(busy_o), .done(done_o),
        .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .rx(rx)
    );
endmodule

// File: rtl/sflash_cmd_engine_chk.sv
module sflash_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    // R8
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n);
    // R5
    sclk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));
    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
endmodule

bind sflash_cmd_engine sflash_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/sflash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sflash_cmd_engine_tb_top;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       busy_o, done_o, spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    always #10 clk = ~clk;

    sflash_cmd_engine #(.HALF_DIV(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_o(busy_o),
        .done_o(done_o), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    logic [7:0]  m_tx [6];
    int          m_cnt;
    bit          m_busy, m_done;
    int          m_t, m_n;
    logic [55:0] m_rx;
    logic [55:0] slave_pat = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_tx[i]) m_tx[i] = 8'h00;
            m_cnt = 0; m_busy = 0; m_done = 0; m_t = 0; m_n = 0; m_rx = '0;
        end else if (m_busy) begin
            m_t = m_t + 1;
            m_done = 0;
            if ((m_t % (2*H)) == H) m_rx = {m_rx[54:0], spi_miso};
            if (m_t == 2*m_n*H) begin
                m_busy = 0;
                m_done = 1;
            end
        end else begin
            m_done = 0;
            if (reg_we) begin
                if (reg_addr == 4'd1) m_cnt = (reg_wdata > 56) ? 56 : int'(reg_wdata);
                if (reg_addr >= 4'd2 && reg_addr <= 4'd7) m_tx[reg_addr - 2] = reg_wdata;
                if (reg_addr == 4'd0 && reg_wdata[0] && m_cnt != 0) begin
                    m_busy = 1; m_t = 0; m_n = m_cnt; m_rx = '0;
                end
            end
        end
    end

    // flash-side data and per-cycle comparison
    always @(negedge clk) begin
        if (m_busy) spi_miso <= slave_pat[55 - m_t/(2*H)];
        else        spi_miso <= 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_cs, e_sclk, e_mosi;
            int k;
            e_cs = 1'b1; e_sclk = 1'b0; e_mosi = 1'b1;
            if (m_busy) begin
                k = m_t / (2*H);
                e_cs = 1'b0;
                e_sclk = ((m_t / H) % 2) == 1;
                e_mosi = (k < 48) ? m_tx[5 - k/8][7 - k%8] : 1'b1;
            end
            // R5 R6 R8 cycle compare
            chk({spi_cs_n, spi_sclk, spi_mosi, busy_o, done_o} ===
                {e_cs, e_sclk, e_mosi, m_busy, m_done},
                "R5/R6/R8 pin compare",
                {spi_cs_n, spi_sclk, spi_mosi, busy_o, done_o},
                {e_cs, e_sclk, e_mosi, m_busy, m_done});
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            report();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({spi_cs_n, spi_sclk, spi_mosi, busy_o, done_o} === 5'b10100, "R1 pins",
            {spi_cs_n, spi_sclk, spi_mosi, busy_o, done_o}, 5'b10100);
        rd(4'd1, 8'h00, "R1 count");
        rd(4'd7, 8'h00, "R1 tx5");
        rd(4'd14, 8'h00, "R1 rx6");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 map, R3 clamp
        wr(4'd7, 8'h9F); wr(4'd6, 8'h12); wr(4'd5, 8'h34); wr(4'd2, 8'hC5);
        rd(4'd7, 8'h9F, "R2 tx5");
        rd(4'd2, 8'hC5, "R2 tx0");
        rd(4'd15, 8'h00, "R2 addr15");
        wr(4'd1, 8'd200);
        rd(4'd1, 8'd56, "R3 clamp 200");
        wr(4'd1, 8'd57);
        rd(4'd1, 8'd56, "R3 clamp 57");

        // R4 zero count start
        wr(4'd1, 8'd0);
        wr(4'd0, 8'h01);
        repeat (4) @(negedge clk);
        chk(busy_o === 1'b0 && spi_cs_n === 1'b1, "R4 zero count idle", {busy_o, spi_cs_n}, 2'b01);

        // R5 R6 opcode only
        wr(4'd1, 8'd8);
        wr(4'd0, 8'h01);
        chk(busy_o === 1'b1, "R8 busy after start", busy_o, 1);
        rd(4'd0, 8'h01, "R2 status busy");
        wait_idle();

        // R7 read three bytes
        slave_pat = 56'h5AC37E_00000000;
        wr(4'd1, 8'd24);
        wr(4'd0, 8'h01);
        wait_idle();
        rd(4'd10, 8'h5A, "R7 rx2 opcode-time byte");
        rd(4'd9,  8'hC3, "R7 rx1 earliest useful");
        rd(4'd8,  8'h7E, "R7 rx0 last useful");
        rd(4'd11, 8'h00, "R7 rx3 untouched");

        // R7 odd length
        slave_pat = 56'hB6D0_0000_0000_00;
        wr(4'd1, 8'd13);
        wr(4'd0, 8'h01);
        wait_idle();
        rd(4'd8, 8'hDA, "R7 13-bit rx0");
        rd(4'd9, 8'h16, "R7 13-bit rx1");

        // R6 full 56 bits with trailing ones, R9 writes during busy
        slave_pat = 56'h0123456789ABCD;
        wr(4'd1, 8'd90);
        wr(4'd0, 8'h01);
        repeat (10) @(negedge clk);
        wr(4'd6, 8'hEE);
        wr(4'd1, 8'd3);
        wait_idle();
        rd(4'd6, 8'h12, "R9 tx4 kept");
        rd(4'd1, 8'd56, "R9 count kept");
        rd(4'd14, 8'h01, "R7 rx6 full");
        rd(4'd8, 8'hCD, "R7 rx0 full");

        // R9 write on the ending edge, R10 start in done cycle
        wr(4'd1, 8'd8);
        wr(4'd0, 8'h01);
        while (!(m_busy && m_t == 2*8*H - 1)) @(negedge clk);
        wr(4'd2, 8'h77);
        chk(done_o === 1'b1, "R8 done at end", done_o, 1);
        wr(4'd0, 8'h01);
        chk(busy_o === 1'b1, "R10 restart in done cycle", busy_o, 1);
        wait_idle();
        rd(4'd2, 8'hC5, "R9 end-edge write dropped");

        repeat (3) @(negedge clk);
        report();
    end
endmodule